// File: doc/BRIEF.md
# Integer Execution Unit for a Three-Operand RISC Core

This block is the integer execute stage of a simple load/store processor. Each cycle it takes one operation code, two 32-bit register operands, a 5-bit shift count and a 16-bit immediate. It produces a 32-bit result and a flag that is high when that result is zero. Instruction decode has already chosen the operation and routed the immediate field onto the `imm` port.

The unit covers register-register add, subtract, AND, OR and NOR. It also covers a signed less-than test that yields 0 or 1, a logical left shift, and the load of an immediate into the upper half of the word. Add, AND, OR and less-than also have immediate forms. NOR is the only inverting primitive, so inverting a single value is done as NOR with zero.

The result and the zero flag are captured in one output register. The branch logic compares two operands for equality by issuing a subtract and reading the zero flag.

Top module: `rint_alu`

## Requirements
- R1: While `rst_n` is low, `result` is 0 and `zero` is 1.
- R2: Codes 0 (add) and 8 (add-immediate) return the sum modulo 2^32. Code 0 adds A and B. Code 8 adds A and the sign-extended `imm`, and B is ignored.
- R3: Code 1 (subtract) returns A minus B in two's complement, wrapping modulo 2^32.
- R4: Codes 2, 3 and 4 return the bitwise AND, OR and NOR (the complement of A OR B) of A and B. NOR with B equal to zero returns the complement of A.
- R5: Codes 9 (AND-immediate) and 10 (OR-immediate) combine A with `imm` zero-extended to 32 bits.
- R6: Codes 5 and 11 return 1 when A is less than the second operand as signed 32-bit numbers, and 0 otherwise. The second operand is B for code 5 and the sign-extended `imm` for code 11. The test stays correct when the subtraction overflows.
- R7: Code 6 returns A shifted left by `shamt` bits with zeros filled in from the right. For example, 0x00000009 shifted by 4 gives 0x00000090.
- R8: Code 7 returns `imm` in bits 31:16 with bits 15:0 cleared. Code 7 with `imm` 61, followed by code 10 with `imm` 2304 applied to that result, gives 0x003D0900.
- R9: `zero` is 1 exactly when `result` is all zeros, and it is updated in the same cycle as `result`.
- R10: Codes 12 to 15 are unused and return 0.
- R11: `result` reflects the inputs present at a rising clock edge, one cycle later. Between edges it holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op | input | 4 | Operation code (see requirements) |
| opnd_a | input | 32 | First source operand |
| opnd_b | input | 32 | Second source operand |
| shamt | input | 5 | Left-shift count |
| imm | input | 16 | Immediate field |
| result | output | 32 | Registered result |
| zero | output | 1 | Registered all-zero flag of `result` |

## Verification
Three things happen on the same subtraction in the same cycle: the signed less-than decision, a possible two's-complement overflow, and, for equal operands, the zero flag. The corner operands 0, 1, 0x7FFFFFFF and 0x80000000 are paired in every combination so that the subtraction overflows in both directions, for example 0x7FFFFFFF against 0x80000000. The less-than output is judged against a signed comparison computed separately in the bench. The zero flag is judged against the expected word of every issued operation, so a subtract of equal operands and a false less-than both require the flag high in the cycle the result lands.

// File: rtl/rint_alu_pkg.sv
package rint_alu_pkg;

    parameter int unsigned XLEN    = 32;
    parameter int unsigned IMM_W   = 16;
    parameter int unsigned SHAMT_W = 5;
    parameter int unsigned OP_W    = 4;

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_AND  = 4'd2,
        OP_OR   = 4'd3,
        OP_NOR  = 4'd4,
        OP_SLT  = 4'd5,
        OP_SLL  = 4'd6,
        OP_LUI  = 4'd7,
        OP_ADDI = 4'd8,
        OP_ANDI = 4'd9,
        OP_ORI  = 4'd10,
        OP_SLTI = 4'd11
    } alu_op_e;

endpackage

// File: rtl/rint_alu_bsel.sv
// Picks the second operand: register value or immediate, extended as the op requires.
module rint_alu_bsel
    import rint_alu_pkg::*;
#(
    parameter int unsigned W     = XLEN,
    parameter int unsigned IMM_W_P = IMM_W
) (
    input  alu_op_e             op,
    input  logic [W-1:0]        b_reg,
    input  logic [IMM_W_P-1:0]  imm,
    output logic [W-1:0]        b_eff,
    output logic                do_sub
);
    localparam int unsigned EXT_W = W - IMM_W_P;

    logic [W-1:0] imm_sext;
    logic [W-1:0] imm_zext;

    assign imm_sext = {{EXT_W{imm[IMM_W_P-1]}}, imm};
    assign imm_zext = {{EXT_W{1'b0}}, imm};

    always_comb begin
        unique case (op)
            OP_ADDI, OP_SLTI: b_eff = imm_sext;
            OP_ANDI, OP_ORI:  b_eff = imm_zext;
            default:          b_eff = b_reg;
        endcase
    end

    always_comb begin
        do_sub = (op == OP_SUB) || (op == OP_SLT) || (op == OP_SLTI);
    end

endmodule

// File: rtl/rint_alu_addsub.sv
// Shared adder/subtractor with an overflow-corrected signed less-than output.
module rint_alu_addsub #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         do_sub,
    output logic [W-1:0] sum,
    output logic         lt_signed
);
    logic [W-1:0] b_x;
    logic         ovf;

    assign b_x = b ^ {W{do_sub}};
    assign sum = a + b_x + {{(W-1){1'b0}}, do_sub};

    // Operands of unlike sign that flip the sign of the difference overflowed.
    assign ovf       = (a[W-1] ^ b[W-1]) & (a[W-1] ^ sum[W-1]);
    assign lt_signed = sum[W-1] ^ ovf;

endmodule

// File: rtl/rint_alu_logic.sv
// Bitwise AND, OR and NOR of the two operands.
module rint_alu_logic #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] and_o,
    output logic [W-1:0] or_o,
    output logic [W-1:0] nor_o
);
    assign and_o = a & b;
    assign or_o  = a | b;
    assign nor_o = ~or_o;

endmodule

// File: rtl/rint_alu_shl.sv
// Logarithmic left shifter, one stage per shift-count bit.
module rint_alu_shl #(
    parameter int unsigned W       = 32,
    parameter int unsigned SHAMT_W_P = 5
) (
    input  logic [W-1:0]         a,
    input  logic [SHAMT_W_P-1:0] sh,
    output logic [W-1:0]         y
);
    logic [W-1:0] stage [0:SHAMT_W_P];

    assign stage[0] = a;

    for (genvar gi = 0; gi < SHAMT_W_P; gi++) begin : g_stage
        localparam int unsigned STEP = 1 << gi;
        assign stage[gi+1] = sh[gi] ? (stage[gi] << STEP) : stage[gi];
    end

    assign y = stage[SHAMT_W_P];

endmodule

// File: rtl/rint_alu.sv
module rint_alu
    import rint_alu_pkg::*;
#(
    parameter int unsigned W         = XLEN,
    parameter int unsigned IMM_W_P   = IMM_W,
    parameter int unsigned SHAMT_W_P = SHAMT_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [OP_W-1:0]      op,
    input  logic [W-1:0]         opnd_a,
    input  logic [W-1:0]         opnd_b,
    input  logic [SHAMT_W_P-1:0] shamt,
    input  logic [IMM_W_P-1:0]   imm,
    output logic [W-1:0]         result,
    output logic                 zero
);
    localparam int unsigned LOW_W = W - IMM_W_P;

    typedef struct packed {
        logic [W-1:0] result;
        logic         zero;
    } out_t;

    alu_op_e      op_e;
    logic [W-1:0] b_eff;
    logic         do_sub;
    logic [W-1:0] sum;
    logic         lt_signed;
    logic [W-1:0] and_v;
    logic [W-1:0] or_v;
    logic [W-1:0] nor_v;
    logic [W-1:0] shl_v;
    out_t         out_d;
    out_t         out_q;

    assign op_e = alu_op_e'(op);

    rint_alu_bsel #(.W(W), .IMM_W_P(IMM_W_P)) u_bsel (
        .op     (op_e),
        .b_reg  (opnd_b),
        .imm    (imm),
        .b_eff  (b_eff),
        .do_sub (do_sub)
    );

    rint_alu_addsub #(.W(W)) u_addsub (
        .a         (opnd_a),
        .b         (b_eff),
        .do_sub    (do_sub),
        .sum       (sum),
        .lt_signed (lt_signed)
    );

    rint_alu_logic #(.W(W)) u_logic (
        .a     (opnd_a),
        .b     (b_eff),
        .and_o (and_v),
        .or_o  (or_v),
        .nor_o (nor_v)
    );

    rint_alu_shl #(.W(W), .SHAMT_W_P(SHAMT_W_P)) u_shl (
        .a  (opnd_a),
        .sh (shamt),
        .y  (shl_v)
    );

    always_comb begin
        out_d = '0;
        unique case (op_e)
            OP_ADD, OP_ADDI, OP_SUB: out_d.result = sum;
            OP_AND, OP_ANDI:         out_d.result = and_v;
            OP_OR, OP_ORI:           out_d.result = or_v;
            OP_NOR:                  out_d.result = nor_v;
            OP_SLT, OP_SLTI:         out_d.result = {{(W-1){1'b0}}, lt_signed};
            OP_SLL:                  out_d.result = shl_v;
            OP_LUI:                  out_d.result = {imm, {LOW_W{1'b0}}};
            default:                 out_d.result = '0;
        endcase
        out_d.zero = (out_d.result == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '{result: '0, zero: 1'b1};
        end else begin
            out_q <= out_d;
        end
    end

    assign result = out_q.result;
    assign zero   = out_q.zero;

endmodule

// File: rtl/rint_alu_chk.sv
module rint_alu_chk
    import rint_alu_pkg::*;
#(
    parameter int unsigned W         = XLEN,
    parameter int unsigned IMM_W_P   = IMM_W,
    parameter int unsigned SHAMT_W_P = SHAMT_W
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [OP_W-1:0]      op,
    input logic [W-1:0]         opnd_a,
    input logic [W-1:0]         opnd_b,
    input logic [SHAMT_W_P-1:0] shamt,
    input logic [IMM_W_P-1:0]   imm,
    input logic [W-1:0]         result,
    input logic                 zero
);
    logic pv_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pv_q <= 1'b0;
        else        pv_q <= 1'b1;
    end

    // R1
    always @(negedge clk) begin
        if (!rst_n) begin
            a_reset_r1: assert (result == '0 && zero == 1'b1)
                else $error("reset state wrong");
        end
    end

    p_zero_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        zero == (result == '0));

    p_sub_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pv_q && $past(op) == OP_SUB) |-> result == ($past(opnd_a) - $past(opnd_b)));

    p_nor_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pv_q && $past(op) == OP_NOR) |->
            ((result & ($past(opnd_a) | $past(opnd_b))) == '0) &&
            ((result | $past(opnd_a) | $past(opnd_b)) == '1));

    p_slt_bool_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pv_q && ($past(op) == OP_SLT || $past(op) == OP_SLTI)) |-> result[W-1:1] == '0);

    p_sll_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pv_q && $past(op) == OP_SLL) |-> result == ($past(opnd_a) << $past(shamt)));

    p_lui_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pv_q && $past(op) == OP_LUI) |-> result == {$past(imm), {(W-IMM_W_P){1'b0}}});

    p_unused_op_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (pv_q && $past(op) > OP_SLTI) |-> result == '0);

endmodule

bind rint_alu rint_alu_chk #(.W(W), .IMM_W_P(IMM_W_P), .SHAMT_W_P(SHAMT_W_P)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .op     (op),
    .opnd_a (opnd_a),
    .opnd_b (opnd_b),
    .shamt  (shamt),
    .imm    (imm),
    .result (result),
    .zero   (zero)
);

// File: tb/rint_alu_tb.sv
module rint_alu_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [3:0]  op;
    logic [31:0] opnd_a;
    logic [31:0] opnd_b;
    logic [4:0]  shamt;
    logic [15:0] imm;
    logic [31:0] result;
    logic        zero;

    int checks   = 0;
    int failures = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [31:0] res;
        logic        z;
        string       req;
    } exp_t;

    exp_t sb_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    rint_alu u_dut (
        .clk    (clk),
        .rst_n  (rst_n),
        .op     (op),
        .opnd_a (opnd_a),
        .opnd_b (opnd_b),
        .shamt  (shamt),
        .imm    (imm),
        .result (result),
        .zero   (zero)
    );

    function automatic logic [31:0] ref_model(input logic [3:0] o, input logic [31:0] a,
                                              input logic [31:0] b, input logic [4:0] s,
                                              input logic [15:0] i);
        logic [31:0] sx;
        logic [31:0] zx;
        sx = {{16{i[15]}}, i};
        zx = {16'h0000, i};
        case (o)
            4'd0:    return a + b;
            4'd1:    return a - b;
            4'd2:    return a & b;
            4'd3:    return a | b;
            4'd4:    return ~(a | b);
            4'd5:    return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
            4'd6:    return a << s;
            4'd7:    return {i, 16'h0000};
            4'd8:    return a + sx;
            4'd9:    return a & zx;
            4'd10:   return a | zx;
            4'd11:   return ($signed(a) < $signed(sx)) ? 32'd1 : 32'd0;
            default: return 32'd0;
        endcase
    endfunction

    function automatic string req_of(input logic [3:0] o);
        case (o)
            4'd0, 4'd8:       return "R2";
            4'd1:             return "R3";
            4'd2, 4'd3, 4'd4: return "R4";
            4'd9, 4'd10:      return "R5";
            4'd5, 4'd11:      return "R6";
            4'd6:             return "R7";
            4'd7:             return "R8";
            default:          return "R10";
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp_v);
        checks++;
        if (act !== exp_v) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp_v);
        end
    endtask

    task automatic drive(input logic [3:0] o, input logic [31:0] a, input logic [31:0] b,
                         input logic [4:0] s, input logic [15:0] i, input string req);
        logic [31:0] r;
        @(negedge clk);
        op     = o;
        opnd_a = a;
        opnd_b = b;
        shamt  = s;
        imm    = i;
        r = ref_model(o, a, b, s, i);
        sb_q.push_back('{res: r, z: (r == 32'd0), req: req});
    endtask

    // Monitor: one registered result per driven item, visible just after the edge (R11).
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                check(e.req, result, e.res);
                check({e.req, "/R9 zero"}, {31'd0, zero}, {31'd0, e.z});
            end
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        logic [31:0] corners [4];
        logic [15:0] imms [4];
        logic [31:0] lui_val;
        corners[0] = 32'h0000_0000;
        corners[1] = 32'h0000_0001;
        corners[2] = 32'h7FFF_FFFF;
        corners[3] = 32'h8000_0000;
        imms[0] = 16'h0000;
        imms[1] = 16'h0001;
        imms[2] = 16'h7FFF;
        imms[3] = 16'h8000;

        rst_n = 1'b0;
        op = 4'd0; opnd_a = 32'd5; opnd_b = 32'd6; shamt = 5'd0; imm = 16'd0;
        repeat (3) @(negedge clk);
        // R1: reset state observed while reset is held, despite non-zero operands
        check("R1 result", result, 32'd0);
        check("R1 zero", {31'd0, zero}, 32'd1);
        rst_n = 1'b1;

        // R7: documented shift example
        drive(4'd6, 32'h0000_0009, 32'd0, 5'd4, 16'd0, "R7");
        drive(4'd6, 32'hFFFF_FFFF, 32'd0, 5'd31, 16'd0, "R7");

        // R8: load upper then OR-immediate on the returned value
        drive(4'd7, 32'hDEAD_BEEF, 32'd0, 5'd0, 16'd61, "R8");
        @(posedge clk);
        #2;
        lui_val = result;
        drive(4'd10, lui_val, 32'd0, 5'd0, 16'd2304, "R8");
        @(posedge clk);
        #2;
        check("R8 chained value", result, 32'h003D_0900);

        // R4: NOR with zero inverts
        drive(4'd4, 32'h0000_3C00, 32'd0, 5'd0, 16'd0, "R4");
        // R9: equal operands subtract to zero, flag high
        drive(4'd1, 32'h1234_5678, 32'h1234_5678, 5'd0, 16'd0, "R9");
        // R2: add-immediate ignores B and sign-extends
        drive(4'd8, 32'd10, 32'hFFFF_0000, 5'd0, 16'hFFFF, "R2");
        // R5: AND/OR immediate zero-extend
        drive(4'd9, 32'hFFFF_FFFF, 32'd0, 5'd0, 16'h8001, "R5");
        drive(4'd10, 32'h0000_0000, 32'hFFFF_FFFF, 5'd0, 16'hF000, "R5");
        // R6: overflowing compares
        drive(4'd5, 32'h7FFF_FFFF, 32'h8000_0000, 5'd0, 16'd0, "R6");
        drive(4'd5, 32'h8000_0000, 32'h7FFF_FFFF, 5'd0, 16'd0, "R6");
        drive(4'd11, 32'h0000_0000, 32'd0, 5'd0, 16'hFFFF, "R6");
        // R10: unused codes
        drive(4'd13, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 5'd3, 16'hFFFF, "R10");

        // R11: output holds until the edge
        drive(4'd3, 32'd0, 32'd0, 5'd0, 16'd0, "R4");
        drive(4'd0, 32'd3, 32'd4, 5'd0, 16'd0, "R11");
        #1;
        check("R11 held before edge", result, 32'd0);

        // Corner operand sweep over every defined op
        for (int o = 0; o < 12; o++) begin
            for (int ai = 0; ai < 4; ai++) begin
                for (int bi = 0; bi < 4; bi++) begin
                    drive(4'(o), corners[ai], corners[bi], 5'(ai * 9 + bi), imms[bi],
                          req_of(4'(o)));
                end
            end
        end

        // Random operands over all codes
        for (int n = 0; n < 600; n++) begin
            logic [3:0] ro;
            ro = 4'($urandom_range(0, 15));
            drive(ro, $urandom, $urandom, 5'($urandom), 16'($urandom), req_of(ro));
        end

        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule